// File: doc/BRIEF.md
# Core and Bus Clock Level Governor

This block decides which clock level the processor core runs at and which level the front-side bus runs at. Software supplies a requested performance level, a permission bit for burst operation and a minimum bus level. The thermal subsystem supplies a headroom flag. The block combines these inputs into a target core level, limited by the peak of the chosen variant and by the burst rules. It derives the bus level from the band of that core level and raises it to the software minimum when needed.

A new selection goes to the clock generator together with a one-cycle strobe. Before any increase in core level, the block asks the external supply for a higher voltage and waits for a ready answer. A decrease, or a change that touches only the bus, is applied on the next clock edge without that handshake. The parameter `TABLET` selects the variant. The phone variant peaks at 1.5 GHz and the tablet variant adds a 1.9 GHz level.

The sequencer has two states. `ST_HOLD` is the steady state: the current selection matches the target, or the block applies a fall at once. `ST_RAMP` waits for voltage-ready before a rise. These transitions connect them:
- HOLD→RAMP when the target core level is above the current one.
- RAMP→HOLD with apply when voltage-ready arrives while the rise is still wanted.
- RAMP→HOLD when the rise is withdrawn. If the target has fallen by then, it is applied at once.
- RAMP→RAMP while still waiting.
- HOLD→HOLD in every other case, with apply whenever the target differs from the current selection.

Top module: `freq_governor`

## Requirements
- R1: After reset the core selection is level 0 (200 MHz) and the bus selection is level 0 (25 MHz). `sel_strobe` and `volt_req` are both low.
- R2: The core level index maps to frequency as 0=200, 1=600, 2=800, 3=1000, 4=1200, 5=1500 and 6=1900 MHz. Level 6 exists only when `TABLET`=1. The core follows `perf_req`, clamped to the highest level of the variant (level 5 by default).
- R3: Levels above 4 are burst levels. The core reaches a burst level only while both `thermal_ok` and `burst_allow` are high. Otherwise a request above 4 yields level 4.
- R4: While the core is at a burst level, a low `thermal_ok` or a low `burst_allow` sampled at a clock edge moves the core to level 4 at that same edge, with a strobe.
- R5: The bus level index maps to frequency as 0=25, 1=50, 2=100 and 3=200 MHz. The bus band is level 3 for core levels above 4, level 2 for core levels 1 to 4, and level 0 for core level 0.
- R6: The bus level is the larger of the band level and `bus_floor`.
- R7: When the core level rises, `volt_req` goes high one cycle after the decision. The selection does not change until `volt_ok` is sampled high during the request. The new selection and the strobe then appear together.
- R8: A lower core level, or a change of the bus level alone, appears on the next clock edge without a voltage request.
- R9: `sel_strobe` is high for exactly the cycles in which the selection differs from the one in the previous cycle.
- R10: `core_sel` and `bus_sel` are one-hot, with bit i standing for level i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perf_req | input | 3 | Requested core level index |
| thermal_ok | input | 1 | Thermal headroom available |
| burst_allow | input | 1 | Software permission for burst levels |
| bus_floor | input | 2 | Software minimum bus level index |
| volt_ok | input | 1 | Supply ready for the requested rise |
| volt_req | output | 1 | Request for higher voltage before a rise |
| core_sel | output | 6 (7 when TABLET=1) | One-hot core level |
| bus_sel | output | 4 | One-hot bus level |
| sel_strobe | output | 1 | New selection applies in this cycle |

## Verification
Directed sequences check each path on its own:
- A bus-only change caused by the floor.
- A rise held back while voltage-ready stays low.
- An entry into burst that is then cut first by loss of headroom and then by loss of permission.
- Requests above the variant peak.

Random stimulus then mixes request, headroom, permission and floor under an automatic ready responder. After each settling period it compares the selections with the bench's own band and clamp functions. This separates errors in the clamp from errors in the burst gating and in the floor maximum.

// File: rtl/gov_pkg.sv
package gov_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RAMP = 1'b1
    } gov_state_t;

    localparam int BUS_LVLS = 4;
    localparam int BUS_W    = $clog2(BUS_LVLS);
    localparam int NOM_TOP  = 4;
    localparam int BUS_HI   = 3;
    localparam int BUS_MID  = 2;
    localparam int BUS_IDLE = 0;
endpackage

// File: rtl/gov_target.sv
module gov_target
    import gov_pkg::*;
#(
    parameter int NCORE = 6,
    parameter int LW    = $clog2(NCORE)
) (
    input  logic [LW-1:0]    req,
    input  logic             headroom,
    input  logic             burst_en,
    input  logic [BUS_W-1:0] floor_lvl,
    output logic [LW-1:0]    tgt_core,
    output logic [BUS_W-1:0] tgt_bus
);
    localparam logic [LW-1:0] TOP = LW'(NCORE - 1);
    localparam logic [LW-1:0] NOM = LW'(NOM_TOP);

    logic [LW-1:0]    lim;
    logic [BUS_W-1:0] band;

    always_comb begin
        lim = (req > TOP) ? TOP : req;
        if (lim > NOM && !(headroom && burst_en)) begin
            lim = NOM;
        end
        if (lim > NOM) begin
            band = BUS_W'(BUS_HI);
        end else if (lim != '0) begin
            band = BUS_W'(BUS_MID);
        end else begin
            band = BUS_W'(BUS_IDLE);
        end
        tgt_core = lim;
        tgt_bus  = (floor_lvl > band) ? floor_lvl : band;
    end
endmodule

// File: rtl/gov_onehot.sv
module gov_onehot #(
    parameter int N = 6,
    parameter int W = $clog2(N)
) (
    input  logic [W-1:0] idx,
    output logic [N-1:0] vec
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign vec[i] = (idx == W'(i));
    end
endmodule

// File: rtl/gov_fsm.sv
module gov_fsm
    import gov_pkg::*;
#(
    parameter int NCORE = 6,
    parameter int LW    = $clog2(NCORE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    tgt_core,
    input  logic [BUS_W-1:0] tgt_bus,
    input  logic             volt_ok,
    output logic [LW-1:0]    cur_core,
    output logic [BUS_W-1:0] cur_bus,
    output logic             chg_stb,
    output logic             volt_req
);
    gov_state_t state_q, state_d;
    logic       do_apply;
    logic       rise;
    logic       differ;

    assign rise   = tgt_core > cur_core;
    assign differ = (tgt_core != cur_core) || (tgt_bus != cur_bus);

    always_comb begin
        state_d  = ST_HOLD;
        do_apply = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (rise) begin
                    state_d = ST_RAMP;
                end else if (differ) begin
                    do_apply = 1'b1;
                end
            end
            ST_RAMP: begin
                if (rise) begin
                    if (volt_ok) begin
                        do_apply = 1'b1;
                    end else begin
                        state_d = ST_RAMP;
                    end
                end else if (differ) begin
                    do_apply = 1'b1;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_core <= '0;
            cur_bus  <= '0;
            chg_stb  <= 1'b0;
            volt_req <= 1'b0;
        end else begin
            if (do_apply) begin
                cur_core <= tgt_core;
                cur_bus  <= tgt_bus;
            end
            chg_stb  <= do_apply;
            volt_req <= (state_d == ST_RAMP);
        end
    end

    // R7: a rise of the core level only lands after a granted voltage request
    assert_rise_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_stb && cur_core > $past(cur_core)) |-> $past(volt_req && volt_ok));

    // R9: strobe marks a real change of selection
    assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stb |-> (cur_core != $past(cur_core) || cur_bus != $past(cur_bus)));

    // R9: no silent change of selection
    assert_change_has_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_core != $past(cur_core) || cur_bus != $past(cur_bus)) |-> chg_stb);

    // R8: falls never need the voltage handshake
    assert_fall_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_core < $past(cur_core)) |-> !$past(volt_req && volt_ok && tgt_core > cur_core));
endmodule

// File: rtl/freq_governor.sv
module freq_governor
    import gov_pkg::*;
#(
    parameter bit TABLET = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   perf_req,
    input  logic                         thermal_ok,
    input  logic                         burst_allow,
    input  logic [1:0]                   bus_floor,
    input  logic                         volt_ok,
    output logic                         volt_req,
    output logic [(TABLET ? 7 : 6)-1:0]  core_sel,
    output logic [3:0]                   bus_sel,
    output logic                         sel_strobe
);
    localparam int NCORE = TABLET ? 7 : 6;
    localparam int LW    = $clog2(NCORE);

    logic [LW-1:0]    tgt_core;
    logic [BUS_W-1:0] tgt_bus;
    logic [LW-1:0]    cur_core;
    logic [BUS_W-1:0] cur_bus;

    gov_target #(.NCORE(NCORE), .LW(LW)) u_target (
        .req       (perf_req),
        .headroom  (thermal_ok),
        .burst_en  (burst_allow),
        .floor_lvl (bus_floor),
        .tgt_core  (tgt_core),
        .tgt_bus   (tgt_bus)
    );

    gov_fsm #(.NCORE(NCORE), .LW(LW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_core (tgt_core),
        .tgt_bus  (tgt_bus),
        .volt_ok  (volt_ok),
        .cur_core (cur_core),
        .cur_bus  (cur_bus),
        .chg_stb  (sel_strobe),
        .volt_req (volt_req)
    );

    gov_onehot #(.N(NCORE), .W(LW)) u_core_oh (.idx(cur_core), .vec(core_sel));
    gov_onehot #(.N(BUS_LVLS), .W(BUS_W)) u_bus_oh (.idx(cur_bus), .vec(bus_sel));

    // R3: a burst level is only held after headroom and permission were both seen
    assert_burst_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_core > LW'(NOM_TOP)) |-> $past(thermal_ok && burst_allow));

    // R6: every applied selection honours the software bus minimum
    assert_bus_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |-> (cur_bus >= $past(bus_floor)));

    // R10: one-hot encodings
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(core_sel) == 1) && ($countones(bus_sel) == 1));
endmodule

// File: tb/freq_governor_bench.sv
`timescale 1ns/1ps
module freq_governor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] perf_req = '0;
    logic       thermal_ok = 1'b0;
    logic       burst_allow = 1'b0;
    logic [1:0] bus_floor = '0;
    logic       vok_man = 1'b0;
    logic       auto_ack = 1'b0;
    logic       vok_auto = 1'b0;
    logic       volt_ok;
    logic       volt_req;
    logic [5:0] core_sel;
    logic [3:0] bus_sel;
    logic       sel_strobe;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always @(posedge clk) vok_auto <= volt_req;
    assign volt_ok = auto_ack ? vok_auto : vok_man;

    freq_governor u_freq_governor (
        .clk(clk), .rst_n(rst_n), .perf_req(perf_req), .thermal_ok(thermal_ok),
        .burst_allow(burst_allow), .bus_floor(bus_floor), .volt_ok(volt_ok),
        .volt_req(volt_req), .core_sel(core_sel), .bus_sel(bus_sel),
        .sel_strobe(sel_strobe)
    );

    function automatic int idx_of(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = (r == -1) ? i : -2;
        return r;
    endfunction

    function automatic int exp_core(input int req, input bit hr, input bit be);
        int r = (req > 5) ? 5 : req;
        if (r > 4 && !(hr && be)) r = 4;
        return r;
    endfunction

    function automatic int exp_bus(input int core, input int fl);
        int b = (core > 4) ? 3 : (core >= 1 ? 2 : 0);
        return (fl > b) ? fl : b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 / R10 reset state
        check("R1 core", idx_of(8'(core_sel)), 0);
        check("R1 bus", idx_of(8'(bus_sel)), 0);
        check("R1 strobe", int'(sel_strobe), 0);
        check("R1 vreq", int'(volt_req), 0);
        step(2);
        check("R9 idle no strobe", int'(sel_strobe), 0);

        // R6 / R8: floor raises bus alone on next edge
        bus_floor = 2'd2;
        step(1);
        check("R6 bus floor", idx_of(8'(bus_sel)), 2);
        check("R8 bus-only strobe", int'(sel_strobe), 1);
        check("R8 no vreq", int'(volt_req), 0);
        step(1);
        check("R9 strobe one cycle", int'(sel_strobe), 0);

        // R7 rise waits for ready
        perf_req = 3'd3;
        step(1);
        check("R7 vreq raised", int'(volt_req), 1);
        step(3);
        check("R7 core held", idx_of(8'(core_sel)), 0);
        check("R7 no strobe while waiting", int'(sel_strobe), 0);
        vok_man = 1'b1;
        step(1);
        vok_man = 1'b0;
        check("R7 core after ready", idx_of(8'(core_sel)), 3);
        check("R7 strobe with change", int'(sel_strobe), 1);
        check("R5 mid band", idx_of(8'(bus_sel)), 2);

        // R2 / R5 burst entry, then R4 headroom loss
        perf_req = 3'd5; thermal_ok = 1'b1; burst_allow = 1'b1; bus_floor = 2'd0;
        step(2);
        vok_man = 1'b1;
        step(1);
        vok_man = 1'b0;
        check("R2 burst level", idx_of(8'(core_sel)), 5);
        check("R5 high band", idx_of(8'(bus_sel)), 3);
        step(2);
        thermal_ok = 1'b0;
        step(1);
        check("R4 drop on headroom loss", idx_of(8'(core_sel)), 4);
        check("R4 strobe", int'(sel_strobe), 1);
        check("R5 band after drop", idx_of(8'(bus_sel)), 2);

        // R2 clamp above peak, then R4 permission loss
        perf_req = 3'd7; thermal_ok = 1'b1;
        step(2);
        vok_man = 1'b1;
        step(1);
        vok_man = 1'b0;
        check("R2 clamp to peak", idx_of(8'(core_sel)), 5);
        burst_allow = 1'b0;
        step(1);
        check("R4 drop on permission loss", idx_of(8'(core_sel)), 4);

        // R3 request above nominal without permission
        perf_req = 3'd6;
        step(4);
        check("R3 no burst", idx_of(8'(core_sel)), 4);
        check("R3 no vreq", int'(volt_req), 0);

        // R8 fall to idle in one edge
        perf_req = 3'd0;
        step(1);
        check("R8 fall core", idx_of(8'(core_sel)), 0);
        check("R5 idle band", idx_of(8'(bus_sel)), 0);

        // random mix under automatic ready
        auto_ack = 1'b1;
        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            int ec, eb;
            perf_req    = 3'($urandom_range(0, 7));
            thermal_ok  = 1'($urandom_range(0, 1));
            burst_allow = 1'($urandom_range(0, 1));
            bus_floor   = 2'($urandom_range(0, 3));
            step(8);
            ec = exp_core(int'(perf_req), thermal_ok, burst_allow);
            eb = exp_bus(ec, int'(bus_floor));
            check("R2/R3 random core", idx_of(8'(core_sel)), ec);
            check("R5/R6 random bus", idx_of(8'(bus_sel)), eb);
            check("R9 random settled strobe", int'(sel_strobe), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(64'd200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule